// File: doc/BRIEF.md
# Dictionary-Indexed Multi-Slot Instruction Expander

This block turns one compact instruction into as many as eight parallel operation slots. Each instruction carries an 8-bit opcode and four shared operand fields. The opcode does not name a single operation. It selects a word in a writable template table. That word gives a size class and up to eight slot templates. Each template fixes the operation code, the signedness and the size or vector mode. It also names which of the four instruction operand fields feeds source A, which feeds source B and which is the destination. Several slots may name the same field, so one operand value can reach many operations.

The table is filled through a load port before a program runs and stays unchanged while instructions decode. The expanded result sits in one output register stage. That stage holds its contents while the downstream stall is high. A table write that arrives while a decode is presented is dropped, and a sticky error flag records it.

Top module: `opdict_expander`

## Requirements
- R1: The table has 256 words and is addressed directly by the 8-bit opcode. A write with `ld_en` high and `in_valid` low stores `ld_word` at `ld_addr`, and a decode of that opcode in the next cycle already sees the new word.
- R2: Word layout: bits [1:0] hold the size-class tag, and slot i occupies bits [2+16i +: 16]. Slot layout: [4:0] operation, [5] signed, [8:6] low three bits of the mode code, [10:9] source-A field select, [12:11] source-B field select, [14:13] destination field select, [15] high bit of the mode code.
- R3: Tag 00 activates slots 0-1, tag 01 activates slots 0-3, tag 10 activates slots 0-7, and tag 11 activates no slot while `out_valid` still reports the instruction.
- R4: Every inactive slot has its valid bit low and all of its fields (operation, signed, mode, sources, destination) at zero.
- R5: For an active slot, `out_src_a`, `out_src_b` and `out_dst` carry operand field `in_opnd[16k +: 16]`, where k is the slot's 2-bit select. Any number of slots may take the same field.
- R6: The operation, signed bit and 4-bit mode code of an active slot are copied from the table word unchanged. The instruction carries none of them. Mode codes 0-3 name the scalar sizes 8/16/32/64, and codes 4-8 name 64v8, 64v16, 64v32, 32v8 and 32v16. The block passes these codes through without interpreting them.
- R7: An instruction accepted at a rising edge (`in_valid` high, `stall` low) appears on the outputs right after that edge. Instructions may be issued back to back, one per cycle.
- R8: While `stall` is high, every output keeps its value and the presented instruction is not taken.
- R9: After an edge with `stall` low and `in_valid` low, `out_valid` and all slot valid bits are low.
- R10: A write with `ld_en` high in a cycle where `in_valid` is high leaves the table unchanged and sets `dict_err`.
- R11: `dict_err` stays set until reset. Reset clears `dict_err` and every output but does not clear the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Table write strobe |
| ld_addr | input | 8 | Table word address |
| ld_word | input | 130 | Table word: tag and eight slot templates |
| in_valid | input | 1 | Instruction presented |
| in_opcode | input | 8 | Instruction opcode (table index) |
| in_opnd | input | 64 | Four 16-bit operand fields, field k at [16k +: 16] |
| stall | input | 1 | Downstream stall: hold the outputs |
| out_valid | output | 1 | Output register holds a decoded instruction |
| out_slot_vld | output | 8 | Per-slot operation valid |
| out_op | output | 40 | Per-slot 5-bit operation code |
| out_sgn | output | 8 | Per-slot signed flag |
| out_mode | output | 32 | Per-slot 4-bit size or vector mode code |
| out_src_a | output | 128 | Per-slot source-A operand value |
| out_src_b | output | 128 | Per-slot source-B operand value |
| out_dst | output | 128 | Per-slot destination operand field |
| dict_err | output | 1 | Sticky flag: a table write collided with a decode |

## Verification
Decodes run through table words of all four tags, each paired with a different operand pattern: four distinct field values, one value repeated in every field, walking single bits, and alternating all-ones and all-zero fields. Distinct values show which field each select chose. Walking bits expose a select that picks a neighbouring field or mixes two fields. Words whose slots repeat the same select show that fields are shared rather than used once. Further sequences separate a write that is honoured from one that is dropped during a decode, an output that holds under stall from one that advances, and the highest opcode from the lowest.

// File: rtl/opdict_pkg.sv
package opdict_pkg;

  localparam int TAG_W    = 2;
  localparam int OP_W     = 5;
  localparam int MODE_W   = 4;
  localparam int SEL_W    = 2;
  localparam int N_FIELDS = 2 ** SEL_W;
  localparam int SLOT_W   = 16;

  // Size class of a table word: how many leading slots are live
  typedef enum logic [TAG_W-1:0] {
    CLS_PAIR  = 2'b00,
    CLS_QUAD  = 2'b01,
    CLS_OCTET = 2'b10,
    CLS_EMPTY = 2'b11
  } size_cls_e;

  // One slot template, LSB first: op, sign, mode[2:0], selects, mode[3]
  typedef struct packed {
    logic             mode_hi;
    logic [SEL_W-1:0] dst_sel;
    logic [SEL_W-1:0] srcb_sel;
    logic [SEL_W-1:0] srca_sel;
    logic [2:0]       mode_lo;
    logic             sgn;
    logic [OP_W-1:0]  op;
  } slot_fld_t;

endpackage

// File: rtl/opdict_store.sv
module opdict_store #(
  parameter int OPC_W  = 8,
  parameter int WORD_W = 130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [OPC_W-1:0]  ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              dec_busy,
  input  logic [OPC_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic              err
);

  localparam int DEPTH = 2 ** OPC_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_ok;
  logic              err_q, err_d;

  // A write is only honoured when no instruction is being decoded
  assign wr_ok = ld_en & ~dec_busy;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[ld_addr] <= ld_word;
    end
  end

  assign rd_word = mem[rd_addr];

  always_comb begin
    err_d = err_q | (ld_en & dec_busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/opdict_class_dec.sv
module opdict_class_dec
  import opdict_pkg::*;
#(
  parameter int N_SLOTS = 8
) (
  input  size_cls_e          cls,
  output logic [N_SLOTS-1:0] act
);

  localparam int CNT_W = $clog2(N_SLOTS + 1);

  logic [CNT_W-1:0] live_cnt;

  always_comb begin
    case (cls)
      CLS_PAIR:  live_cnt = CNT_W'(N_SLOTS / 4);
      CLS_QUAD:  live_cnt = CNT_W'(N_SLOTS / 2);
      CLS_OCTET: live_cnt = CNT_W'(N_SLOTS);
      default:   live_cnt = '0;
    endcase
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_act
    assign act[i] = (CNT_W'(i) < live_cnt);
  end

endmodule

// File: rtl/opdict_slot_route.sv
module opdict_slot_route
  import opdict_pkg::*;
#(
  parameter int OPND_W = 16
) (
  input  slot_fld_t                  fld,
  input  logic                       act,
  input  logic [N_FIELDS*OPND_W-1:0] opnd,
  output logic                       vld,
  output logic [OP_W-1:0]            op,
  output logic                       sgn,
  output logic [MODE_W-1:0]          mode,
  output logic [OPND_W-1:0]          src_a,
  output logic [OPND_W-1:0]          src_b,
  output logic [OPND_W-1:0]          dst
);

  logic [OPND_W-1:0] field_arr [N_FIELDS];

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_split
    assign field_arr[k] = opnd[k*OPND_W +: OPND_W];
  end

  always_comb begin
    vld   = act;
    op    = '0;
    sgn   = 1'b0;
    mode  = '0;
    src_a = '0;
    src_b = '0;
    dst   = '0;
    if (act) begin
      op    = fld.op;
      sgn   = fld.sgn;
      mode  = {fld.mode_hi, fld.mode_lo};
      src_a = field_arr[fld.srca_sel];
      src_b = field_arr[fld.srcb_sel];
      dst   = field_arr[fld.dst_sel];
    end
  end

endmodule

// File: rtl/opdict_expander.sv
module opdict_expander
  import opdict_pkg::*;
#(
  parameter int OPC_W   = 8,
  parameter int OPND_W  = 16,
  parameter int N_SLOTS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [OPC_W-1:0]              ld_addr,
  input  logic [TAG_W+N_SLOTS*SLOT_W-1:0] ld_word,
  input  logic                          in_valid,
  input  logic [OPC_W-1:0]              in_opcode,
  input  logic [N_FIELDS*OPND_W-1:0]    in_opnd,
  input  logic                          stall,
  output logic                          out_valid,
  output logic [N_SLOTS-1:0]            out_slot_vld,
  output logic [N_SLOTS*OP_W-1:0]       out_op,
  output logic [N_SLOTS-1:0]            out_sgn,
  output logic [N_SLOTS*MODE_W-1:0]     out_mode,
  output logic [N_SLOTS*OPND_W-1:0]     out_src_a,
  output logic [N_SLOTS*OPND_W-1:0]     out_src_b,
  output logic [N_SLOTS*OPND_W-1:0]     out_dst,
  output logic                          dict_err
);

  localparam int WORD_W = TAG_W + N_SLOTS * SLOT_W;
  localparam int OPW    = N_SLOTS * OPND_W;

  logic [WORD_W-1:0]        rd_word;
  size_cls_e                cls;
  logic [N_SLOTS-1:0]       act;

  logic [N_SLOTS-1:0]       dec_vld, dec_sgn;
  logic [N_SLOTS*OP_W-1:0]  dec_op;
  logic [N_SLOTS*MODE_W-1:0] dec_mode;
  logic [OPW-1:0]           dec_a, dec_b, dec_d;

  opdict_store #(
    .OPC_W  (OPC_W),
    .WORD_W (WORD_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_word  (ld_word),
    .dec_busy (in_valid),
    .rd_addr  (in_opcode),
    .rd_word  (rd_word),
    .err      (dict_err)
  );

  assign cls = size_cls_e'(rd_word[TAG_W-1:0]);

  opdict_class_dec #(
    .N_SLOTS (N_SLOTS)
  ) u_cls (
    .cls (cls),
    .act (act)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    slot_fld_t fld;
    assign fld = slot_fld_t'(rd_word[TAG_W + i*SLOT_W +: SLOT_W]);

    opdict_slot_route #(
      .OPND_W (OPND_W)
    ) u_route (
      .fld   (fld),
      .act   (act[i]),
      .opnd  (in_opnd),
      .vld   (dec_vld[i]),
      .op    (dec_op[i*OP_W +: OP_W]),
      .sgn   (dec_sgn[i]),
      .mode  (dec_mode[i*MODE_W +: MODE_W]),
      .src_a (dec_a[i*OPND_W +: OPND_W]),
      .src_b (dec_b[i*OPND_W +: OPND_W]),
      .dst   (dec_d[i*OPND_W +: OPND_W])
    );
  end

  // Output stage: next-state selection
  logic                      adv;
  logic                      nx_valid, q_valid;
  logic [N_SLOTS-1:0]        nx_vld, q_vld, nx_sgn, q_sgn;
  logic [N_SLOTS*OP_W-1:0]   nx_op, q_op;
  logic [N_SLOTS*MODE_W-1:0] nx_mode, q_mode;
  logic [OPW-1:0]            nx_a, q_a, nx_b, q_b, nx_d, q_d;

  assign adv = ~stall;

  always_comb begin
    nx_valid = in_valid;
    nx_vld   = '0;
    nx_sgn   = '0;
    nx_op    = '0;
    nx_mode  = '0;
    nx_a     = '0;
    nx_b     = '0;
    nx_d     = '0;
    if (in_valid) begin
      nx_vld  = dec_vld;
      nx_sgn  = dec_sgn;
      nx_op   = dec_op;
      nx_mode = dec_mode;
      nx_a    = dec_a;
      nx_b    = dec_b;
      nx_d    = dec_d;
    end
  end

  // Output stage: registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_vld   <= '0;
      q_sgn   <= '0;
      q_op    <= '0;
      q_mode  <= '0;
      q_a     <= '0;
      q_b     <= '0;
      q_d     <= '0;
    end else if (adv) begin
      q_valid <= nx_valid;
      q_vld   <= nx_vld;
      q_sgn   <= nx_sgn;
      q_op    <= nx_op;
      q_mode  <= nx_mode;
      q_a     <= nx_a;
      q_b     <= nx_b;
      q_d     <= nx_d;
    end
  end

  assign out_valid    = q_valid;
  assign out_slot_vld = q_vld;
  assign out_sgn      = q_sgn;
  assign out_op       = q_op;
  assign out_mode     = q_mode;
  assign out_src_a    = q_a;
  assign out_src_b    = q_b;
  assign out_dst      = q_d;

endmodule

// File: rtl/opdict_expander_chk.sv
module opdict_expander_chk #(
  parameter int N_SLOTS = 8,
  parameter int OPND_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ld_en,
  input logic                      in_valid,
  input logic                      stall,
  input logic                      out_valid,
  input logic [N_SLOTS-1:0]        out_slot_vld,
  input logic [N_SLOTS*5-1:0]      out_op,
  input logic [N_SLOTS*4-1:0]      out_mode,
  input logic [N_SLOTS*OPND_W-1:0] out_src_a,
  input logic [N_SLOTS*OPND_W-1:0] out_src_b,
  input logic [N_SLOTS*OPND_W-1:0] out_dst,
  input logic                      dict_err
);

  // R3: live slots form a prefix of size 0, N/4, N/2 or N
  p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_slot_vld & (out_slot_vld + 1'b1)) == '0) &&
    ($countones(out_slot_vld) == 0 || $countones(out_slot_vld) == N_SLOTS/4 ||
     $countones(out_slot_vld) == N_SLOTS/2 || $countones(out_slot_vld) == N_SLOTS));

  // R3: no slot is live without an instruction
  p_slot_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_slot_vld != '0) |-> out_valid);

  // R4: inactive slots carry zeros
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_zero
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_slot_vld[i] |-> (out_src_a[i*OPND_W +: OPND_W] == '0 &&
                            out_src_b[i*OPND_W +: OPND_W] == '0 &&
                            out_dst[i*OPND_W +: OPND_W] == '0 &&
                            out_op[i*5 +: 5] == '0 && out_mode[i*4 +: 4] == '0));
  end

  // R7: one-cycle latency of the valid
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (out_valid == $past(in_valid)));

  // R8: stall freezes the outputs
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(out_valid) && $stable(out_slot_vld) && $stable(out_op) &&
               $stable(out_src_a) && $stable(out_src_b) && $stable(out_dst)));

  // R9: idle cycle clears the outputs
  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !in_valid) |=> (!out_valid && out_slot_vld == '0));

  // R10: colliding write raises the error
  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && in_valid) |=> dict_err);

  // R11: error is sticky
  p_err_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dict_err |=> dict_err);

endmodule

bind opdict_expander opdict_expander_chk #(
  .N_SLOTS (N_SLOTS),
  .OPND_W  (OPND_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_en        (ld_en),
  .in_valid     (in_valid),
  .stall        (stall),
  .out_valid    (out_valid),
  .out_slot_vld (out_slot_vld),
  .out_op       (out_op),
  .out_mode     (out_mode),
  .out_src_a    (out_src_a),
  .out_src_b    (out_src_b),
  .out_dst      (out_dst),
  .dict_err     (dict_err)
);

// File: tb/sim_opdict_expander.sv
module sim_opdict_expander;

  localparam int N  = 8;
  localparam int W  = 16;
  localparam int WW = 2 + N*16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ld_en;
  logic [7:0]      ld_addr;
  logic [WW-1:0]   ld_word;
  logic            in_valid;
  logic [7:0]      in_opcode;
  logic [4*W-1:0]  in_opnd;
  logic            stall;
  logic            out_valid;
  logic [N-1:0]    out_slot_vld, out_sgn;
  logic [N*5-1:0]  out_op;
  logic [N*4-1:0]  out_mode;
  logic [N*W-1:0]  out_src_a, out_src_b, out_dst;
  logic            dict_err;

  opdict_expander u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
    .in_valid(in_valid), .in_opcode(in_opcode), .in_opnd(in_opnd), .stall(stall),
    .out_valid(out_valid), .out_slot_vld(out_slot_vld), .out_op(out_op),
    .out_sgn(out_sgn), .out_mode(out_mode), .out_src_a(out_src_a),
    .out_src_b(out_src_b), .out_dst(out_dst), .dict_err(dict_err)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [N-1:0]   vld;
    logic [N*5-1:0] op;
    logic [N-1:0]   sgn;
    logic [N*4-1:0] mode;
    logic [N*W-1:0] a, b, d;
    string          tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [WW-1:0] dict_m [256];
  int            checks = 0;
  int            fails  = 0;
  logic          acc_q  = 1'b0;
  logic          done   = 1'b0;

  // Slot template per R2
  function automatic logic [15:0] mk_slot(int s);
    logic [4:0] op; logic sg; logic [3:0] md; logic [1:0] sa, sb, sd;
    op = 5'(s*7 + 3);
    sg = 1'((s >> 1) & 1);
    md = 4'(s % 9);
    sa = 2'(s);
    sb = 2'(s/4 + 1);
    sd = 2'(s*3 + 2);
    return {md[3], sd, sb, sa, md[2:0], sg, op};
  endfunction

  function automatic logic [WW-1:0] mk_word(int e, int salt);
    logic [WW-1:0] w;
    w[1:0] = 2'(e);
    for (int j = 0; j < N; j++) w[2+16*j +: 16] = mk_slot(e*8 + j + salt);
    return w;
  endfunction

  // Expected expansion per R3..R6
  function automatic exp_t model(logic [WW-1:0] w, logic [4*W-1:0] op_in, string tag);
    exp_t r; int n; logic [15:0] s;
    case (w[1:0]) 2'b00: n = 2; 2'b01: n = 4; 2'b10: n = 8; default: n = 0; endcase
    r.vld = '0; r.op = '0; r.sgn = '0; r.mode = '0; r.a = '0; r.b = '0; r.d = '0; r.tag = tag;
    for (int j = 0; j < n; j++) begin
      s = w[2+16*j +: 16];
      r.vld[j]        = 1'b1;
      r.op[j*5 +: 5]  = s[4:0];
      r.sgn[j]        = s[5];
      r.mode[j*4 +: 4] = {s[15], s[8:6]};
      r.a[j*W +: W]   = op_in[s[10:9]*W +: W];
      r.b[j*W +: W]   = op_in[s[12:11]*W +: W];
      r.d[j*W +: W]   = op_in[s[14:13]*W +: W];
    end
    return r;
  endfunction

  function automatic logic [4*W-1:0] pattern(int p);
    case (p % 4)
      0: return {16'h4444, 16'h3333, 16'h2222, 16'h1111};
      1: return {4{16'hA5A5}};
      2: return {16'h8000, 16'h0400, 16'h0020, 16'h0001};
      default: return {16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF};
    endcase
  endfunction

  task automatic chk(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(int a, logic [WW-1:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(a); ld_word = w; in_valid = 1'b0; stall = 1'b0;
    dict_m[a] = w;
  endtask

  task automatic issue(int opc, logic [4*W-1:0] op_in, string tag);
    @(negedge clk);
    ld_en = 1'b0; in_valid = 1'b1; in_opcode = 8'(opc); in_opnd = op_in; stall = 1'b0;
    exp_q.push_back(model(dict_m[opc], op_in, tag));
  endtask

  // Decode with a colliding write: write must be dropped (R10)
  task automatic issue_collide(int opc, logic [4*W-1:0] op_in, int wa, logic [WW-1:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(wa); ld_word = w;
    in_valid = 1'b1; in_opcode = 8'(opc); in_opnd = op_in; stall = 1'b0;
    exp_q.push_back(model(dict_m[opc], op_in, "R10"));
  endtask

  task automatic idle();
    @(negedge clk);
    ld_en = 1'b0; in_valid = 1'b0; stall = 1'b0;
  endtask

  // Monitor: compare each freshly captured instruction
  always @(posedge clk) acc_q <= rst_n && in_valid && !stall;

  always @(negedge clk) begin
    if (acc_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7: output produced with no expected item, vld=%h", out_slot_vld);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_valid !== 1'b1 || out_slot_vld !== e.vld || out_op !== e.op ||
            out_sgn !== e.sgn || out_mode !== e.mode || out_src_a !== e.a ||
            out_src_b !== e.b || out_dst !== e.d) begin
          fails++;
          $display("FAIL %s: actual v=%b vld=%h op=%h sg=%h md=%h a=%h b=%h d=%h expected vld=%h op=%h sg=%h md=%h a=%h b=%h d=%h",
                   e.tag, out_valid, out_slot_vld, out_op, out_sgn, out_mode, out_src_a,
                   out_src_b, out_dst, e.vld, e.op, e.sgn, e.mode, e.a, e.b, e.d);
        end
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual still running expected finished");
      report();
      $finish;
    end
  end

  initial begin
    exp_t held;
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_word = '0;
    in_valid = 1'b0; in_opcode = '0; in_opnd = '0; stall = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset valid", N*W'(out_valid), '0);
    chk("R11 reset slots", N*W'(out_slot_vld), '0);
    chk("R11 reset src_a", out_src_a, '0);
    chk("R11 reset err", N*W'(dict_err), '0);
    rst_n = 1'b1;

    // R1/R2: fill entries 0..15 and the top entry
    for (int e = 0; e < 16; e++) load(e, mk_word(e, 0));
    load(255, mk_word(2, 77));

    // R3/R4/R5/R6/R7: back-to-back decodes over all tags and patterns
    for (int e = 0; e < 16; e++) issue(e, pattern(e + e/4), "R5 R6 R3 R7 decode");
    issue(255, pattern(2), "R1 top opcode");
    issue(0, pattern(0), "R7 back-to-back");

    // R9: idle after activity
    idle();
    @(negedge clk);
    chk("R9 idle valid", N*W'(out_valid), '0);
    chk("R9 idle slots", N*W'(out_slot_vld), '0);

    // R8: stall holds outputs and ignores the presented instruction
    issue(6, pattern(1), "R8 before stall");
    held = model(dict_m[6], pattern(1), "R8");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      stall = 1'b1; in_valid = 1'b1; in_opcode = 8'd2; in_opnd = pattern(3);
    end
    @(negedge clk);
    chk("R8 held slots", N*W'(out_slot_vld), N*W'(held.vld));
    chk("R8 held src_a", out_src_a, held.a);
    chk("R8 held dst", out_dst, held.d);
    stall = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 after stall", N*W'(out_slot_vld), '0);

    // R10: write during decode is dropped and flags the error
    chk("R10 err before", N*W'(dict_err), '0);
    issue_collide(5, pattern(0), 3, mk_word(2, 500));
    idle();
    chk("R10 err set", N*W'(dict_err), N*W'(1));
    issue(3, pattern(2), "R10 entry unchanged");

    // R1: honoured rewrite visible to the very next decode
    load(9, mk_word(10, 300));
    issue(9, pattern(0), "R1 rewrite");
    load(1, mk_word(3, 40));
    issue(1, pattern(1), "R3 empty tag");
    idle();
    repeat (4) @(negedge clk);
    chk("R11 err sticky", N*W'(dict_err), N*W'(1));

    // R11: reset clears the flag but keeps the table
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 err cleared", N*W'(dict_err), '0);
    chk("R11 out cleared", N*W'(out_valid), '0);
    rst_n = 1'b1;
    issue(255, pattern(3), "R11 table kept");
    idle();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R7: actual %0d items pending expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
    $finish;
  end

endmodule